// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block fronts a small on-chip flash array. It takes byte writes to either a control register or the array itself, and it drives the high-voltage steps of erase and page programming. Each step has to arrive in a fixed order. The controller enforces that order, times the high-voltage phases in clock cycles and holds the array out of read access until the discharge wait is over. An erased byte reads as 0x00. Programming ORs new one-bits into a byte.

An erase acts on a region whose size comes from two select bits. The region is the set of bytes whose upper address bits match the address latched from the array write of that sequence. Programming works on one 8-byte page that is aligned to a multiple of eight. Each row keeps a count of completed program operations. Once a row reaches the limit it refuses further programming until it is erased. Three one-cycle pulses report errors: a step out of order, a high-voltage request while interrupts are not masked, and a program attempt on a locked row.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset every array byte reads 0x00, and `busy`, `seq_err`, `mask_err` and `lock_err` are all low.
- R2: A control write uses this layout: bit 0 program, bit 1 erase, bit 2 high-voltage enable, bits 4:3 region select, bits 7:5 zero. An erase runs in this order:
  - write control 0x02 with the select bits set;
  - write to the array (its address is latched);
  - write control 0x06;
  - wait;
  - write control 0x04;
  - write control 0x00.
- R3: Region select 00 erases the whole array. Select 01 erases the half that shares the top address bit. Select 10 erases the 512-byte group of eight rows that shares address bits 10:9. Select 11 erases the 64-byte row that shares bits 10:6. Bytes outside the region keep their value.
- R4: A program runs in this order:
  - write control 0x01;
  - write one or more bytes of one aligned 8-byte page (the first write picks the page);
  - write control 0x05;
  - wait;
  - write control 0x04;
  - write control 0x00.

  Each byte written is ORed into the stored byte, and the other bytes of the page are unchanged.
- R5: A control write that moves from an armed step to high voltage while `irq_masked` is 0 pulses `mask_err`. The sequence is dropped, `busy` stays low and the array is unchanged.
- R6: `busy` goes high on the clock edge that takes the high-voltage write. Take the edge that takes the high-voltage-off write as edge m: `busy` stays high through edge m+T_KILL and falls at edge m+T_KILL+1. While `busy` is high, reads return 0x00.
- R7: The write that clears erase or program must come at least T+1 clock edges after the high-voltage write, where T is T_ERASE or T_PROG. An earlier clear pulses `seq_err`, leaves the array unchanged and goes straight to the discharge wait.
- R8: Reads and control writes that repeat the current step's bits may fall between steps without aborting the sequence.
- R9: A control write with any other value pulses `seq_err` and drops the sequence. An array write that no step expects pulses `seq_err` and is ignored. This includes a write to a page other than the latched one.
- R10: A row that has had MAX_PROG (8) completed program operations since its last erase refuses the first array write of a new program sequence. That write pulses `lock_err` and the sequencer returns to idle. Erasing the row clears its count.
- R11: Each error flag is a single-cycle pulse in the cycle after the offending write, and at most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_masked | input | 1 | High while the processor has interrupts masked |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_ctrl | input | 1 | 1: write targets the control register, 0: the array |
| addr | input | ADDR_W | Array address for writes and reads |
| wdata | input | 8 | Write data or control value |
| rdata | output | 8 | Array byte at `addr`, 0x00 while busy |
| busy | output | 1 | High-voltage phase or discharge wait in progress |
| seq_err | output | 1 | Pulse: step out of order or too early |
| mask_err | output | 1 | Pulse: high voltage requested without the interrupt mask |
| lock_err | output | 1 | Pulse: program refused on a row at its limit |

## Verification
Pages are seeded into every quarter of the array first. Erases with each of the four select values are then applied in turn, and a full read sweep follows each one. This shows whether the region compare uses the right address bits for each select value. Programming is tried on a single byte, on a byte hit twice with disjoint bit patterns, and on several bytes of one page. These cases show OR-ing apart from overwriting and show that the page is picked by the first write. Faulty sequences are also applied: an early clear, a missing mask, a wrong command, a stray page write and a ninth program on one row. Each is checked to raise only its own flag and to leave the array unchanged, and the row count is checked to reset after an erase.

// File: rtl/flash_seq_pkg.sv
// Shared types and helpers for the flash sequencer.
// Assumes byte-wide data and power-of-two row and page sizes.
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E_ARM,
        ST_E_LAT,
        ST_E_HV,
        ST_P_ARM,
        ST_P_LAT,
        ST_P_HV,
        ST_HV_END,
        ST_DISCH
    } seq_state_e;

    // Command codes: {wdata[7:5], wdata[2:0]} with the select bits removed.
    localparam logic [5:0] CMD_OFF   = 6'b000_000;
    localparam logic [5:0] CMD_PROG  = 6'b000_001;
    localparam logic [5:0] CMD_ERASE = 6'b000_010;
    localparam logic [5:0] CMD_HV    = 6'b000_100;
    localparam logic [5:0] CMD_P_HV  = 6'b000_101;
    localparam logic [5:0] CMD_E_HV  = 6'b000_110;

    // Lowest address bit that must match for an erase region.
    function automatic int region_lsb(input logic [1:0] sel, input int addr_w,
                                      input int row_lsb);
        case (sel)
            2'b00:   return addr_w;
            2'b01:   return addr_w - 1;
            2'b10:   return row_lsb + 3;
            default: return row_lsb;
        endcase
    endfunction

endpackage

// File: rtl/flash_page_buf.sv
// Page buffer: collects the bytes of one program page.
// The first write clears the other bytes. Later writes OR into their byte.
module flash_page_buf #(
    parameter int PAGE_LSB = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          wr,
    input  logic [PAGE_LSB-1:0]           idx,
    input  logic [7:0]                    wbyte,
    output logic [(1<<PAGE_LSB)*8-1:0]    page_data
);
    localparam int PAGE = 1 << PAGE_LSB;

    for (genvar j = 0; j < PAGE; j++) begin : g_byte
        logic [7:0] b;
        // Capture or merge the byte held at slot j.
        always_ff @(posedge clk) begin
            if (!rst_n)
                b <= 8'h00;
            else if (load)
                b <= (idx == PAGE_LSB'(j)) ? wbyte : 8'h00;
            else if (wr && idx == PAGE_LSB'(j))
                b <= b | wbyte;
        end
        assign page_data[j*8 +: 8] = b;
    end
endmodule

// File: rtl/flash_cell_array.sv
// Behavioural flash array kept as one packed vector per row.
// Each row also holds a count of completed program operations.
// Assumes that erase_go and prog_go never rise together.
module flash_cell_array #(
    parameter int ADDR_W   = 11,
    parameter int ROW_LSB  = 6,
    parameter int PAGE_LSB = 3,
    parameter int MAX_PROG = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase_go,
    input  logic                          prog_go,
    input  logic [ADDR_W-1:0]             tgt_addr,
    input  logic [1:0]                    region_sel,
    input  logic [(1<<PAGE_LSB)*8-1:0]    pb_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_byte,
    output logic [$clog2(MAX_PROG+1)-1:0] rd_row_cnt
);
    import flash_seq_pkg::*;

    localparam int ROWS      = 1 << (ADDR_W - ROW_LSB);
    localparam int ROW_BITS  = (1 << ROW_LSB) * 8;
    localparam int PAGE_BITS = (1 << PAGE_LSB) * 8;
    localparam int RIW       = ADDR_W - ROW_LSB;
    localparam int PIW       = ROW_LSB - PAGE_LSB;
    localparam int CW        = $clog2(MAX_PROG + 1);

    logic [ROW_BITS-1:0] row_data [ROWS];
    logic [CW-1:0]       row_cnt  [ROWS];
    logic [RIW-1:0]      tgt_row;
    logic [PIW-1:0]      tgt_pg;
    int                  cmp_lsb;

    // Decode the target row, the page inside it and the region compare depth.
    always_comb begin
        tgt_row = tgt_addr[ADDR_W-1:ROW_LSB];
        tgt_pg  = tgt_addr[ROW_LSB-1:PAGE_LSB];
        cmp_lsb = region_lsb(region_sel, ADDR_W, ROW_LSB);
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_BITS-1:0] bits;
        logic [CW-1:0]       cnt;
        logic                hit_e;
        logic                hit_p;
        assign hit_e = erase_go &&
                       (((ADDR_W'(r << ROW_LSB) ^ tgt_addr) >> cmp_lsb) == '0);
        assign hit_p = prog_go && (tgt_row == RIW'(r));
        // Clear the row on erase, or OR the page in and count on program.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits <= '0;
                cnt  <= '0;
            end else if (hit_e) begin
                bits <= '0;
                cnt  <= '0;
            end else if (hit_p) begin
                bits[tgt_pg*PAGE_BITS +: PAGE_BITS] <=
                    bits[tgt_pg*PAGE_BITS +: PAGE_BITS] | pb_data;
                cnt <= cnt + CW'(1);
            end
        end
        assign row_data[r] = bits;
        assign row_cnt[r]  = cnt;
    end

    // Read the byte and the row count at the bus address.
    always_comb begin
        rd_byte    = row_data[rd_addr[ADDR_W-1:ROW_LSB]][rd_addr[ROW_LSB-1:0]*8 +: 8];
        rd_row_cnt = row_cnt[rd_addr[ADDR_W-1:ROW_LSB]];
    end
endmodule

// File: rtl/flash_seq_fsm.sv
// Step sequencer for erase and program, with a cycle timer for each
// high-voltage phase. Assumes each bus write lasts one cycle. Reads
// never change the state.
module flash_seq_fsm #(
    parameter int ADDR_W   = 11,
    parameter int PAGE_LSB = 3,
    parameter int T_ERASE  = 20,
    parameter int T_PROG   = 12,
    parameter int T_KILL   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        irq_masked,
    input  logic                        wr_en,
    input  logic                        wr_ctrl,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    input  logic                        locked,
    output flash_seq_pkg::seq_state_e   state,
    output logic                        busy,
    output logic [ADDR_W-1:0]           lat_addr,
    output logic [1:0]                  region_sel,
    output logic                        erase_go,
    output logic                        prog_go,
    output logic                        pb_load,
    output logic                        pb_wr,
    output logic                        tmr_zero,
    output logic                        seq_err,
    output logic                        mask_err,
    output logic                        lock_err
);
    import flash_seq_pkg::*;

    localparam int TMAX = (T_ERASE > T_PROG) ?
                          ((T_ERASE > T_KILL) ? T_ERASE : T_KILL) :
                          ((T_PROG > T_KILL) ? T_PROG : T_KILL);
    localparam int TW = $clog2(TMAX + 1);

    logic [TW-1:0] tmr;
    logic [5:0]    cmd;
    logic          cw;
    logic          aw;
    logic          same_page;

    // Classify the bus write and decode the command.
    always_comb begin
        cw        = wr_en && wr_ctrl;
        aw        = wr_en && !wr_ctrl;
        cmd       = {wdata[7:5], wdata[2:0]};
        same_page = addr[ADDR_W-1:PAGE_LSB] == lat_addr[ADDR_W-1:PAGE_LSB];
        tmr_zero  = (tmr == '0);
        busy      = state inside {ST_E_HV, ST_P_HV, ST_HV_END, ST_DISCH};
        pb_load   = aw && state == ST_P_ARM && !locked;
        pb_wr     = aw && state == ST_P_LAT && same_page;
    end

    // Advance the step order, run the timer and raise one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tmr        <= '0;
            lat_addr   <= '0;
            region_sel <= 2'b00;
            erase_go   <= 1'b0;
            prog_go    <= 1'b0;
            seq_err    <= 1'b0;
            mask_err   <= 1'b0;
            lock_err   <= 1'b0;
        end else begin
            erase_go <= 1'b0;
            prog_go  <= 1'b0;
            seq_err  <= 1'b0;
            mask_err <= 1'b0;
            lock_err <= 1'b0;
            if (!tmr_zero) tmr <= tmr - TW'(1);
            case (state)
                ST_IDLE: begin
                    if (cw && cmd == CMD_ERASE) begin
                        state      <= ST_E_ARM;
                        region_sel <= wdata[4:3];
                    end else if (cw && cmd == CMD_PROG) begin
                        state <= ST_P_ARM;
                    end else if ((cw && cmd != CMD_OFF) || aw) begin
                        seq_err <= 1'b1;
                    end
                end
                ST_E_ARM: begin
                    if (aw) begin
                        lat_addr <= addr;
                        state    <= ST_E_LAT;
                    end else if (cw && cmd != CMD_ERASE) begin
                        seq_err <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_E_LAT: begin
                    if (cw && cmd == CMD_E_HV) begin
                        if (irq_masked) begin
                            state <= ST_E_HV;
                            tmr   <= TW'(T_ERASE);
                        end else begin
                            mask_err <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end else if (cw && cmd != CMD_ERASE) begin
                        seq_err <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (aw) begin
                        seq_err <= 1'b1;
                    end
                end
                ST_P_ARM: begin
                    if (aw && locked) begin
                        lock_err <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (aw) begin
                        lat_addr <= addr;
                        state    <= ST_P_LAT;
                    end else if (cw && cmd != CMD_PROG) begin
                        seq_err <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_P_LAT: begin
                    if (cw && cmd == CMD_P_HV) begin
                        if (irq_masked) begin
                            state <= ST_P_HV;
                            tmr   <= TW'(T_PROG);
                        end else begin
                            mask_err <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end else if (cw && cmd != CMD_PROG) begin
                        seq_err <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (aw && !same_page) begin
                        seq_err <= 1'b1;
                    end
                end
                ST_E_HV, ST_P_HV: begin
                    if (cw && cmd == CMD_HV) begin
                        if (tmr_zero) begin
                            erase_go <= (state == ST_E_HV);
                            prog_go  <= (state == ST_P_HV);
                            state    <= ST_HV_END;
                        end else begin
                            seq_err <= 1'b1;
                            state   <= ST_DISCH;
                            tmr     <= TW'(T_KILL);
                        end
                    end else if (cw && cmd != ((state == ST_E_HV) ? CMD_E_HV : CMD_P_HV)) begin
                        seq_err <= 1'b1;
                        state   <= ST_DISCH;
                        tmr     <= TW'(T_KILL);
                    end else if (aw) begin
                        seq_err <= 1'b1;
                    end
                end
                ST_HV_END: begin
                    if (cw && cmd != CMD_HV) begin
                        seq_err <= (cmd != CMD_OFF);
                        state   <= ST_DISCH;
                        tmr     <= TW'(T_KILL);
                    end else if (aw) begin
                        seq_err <= 1'b1;
                    end
                end
                ST_DISCH: begin
                    if (tmr_zero) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
// Top of the flash erase/program sequencer. It joins the step FSM, the
// page buffer and the array model. Assumes that a write and a read never
// share a cycle.
module flash_seq_ctrl #(
    parameter int ADDR_W   = 11,
    parameter int ROW_LSB  = 6,
    parameter int PAGE_LSB = 3,
    parameter int MAX_PROG = 8,
    parameter int T_ERASE  = 20,
    parameter int T_PROG   = 12,
    parameter int T_KILL   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_masked,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              seq_err,
    output logic              mask_err,
    output logic              lock_err
);
    import flash_seq_pkg::*;

    localparam int CW = $clog2(MAX_PROG + 1);
    localparam int PB = (1 << PAGE_LSB) * 8;

    seq_state_e        st;
    logic [ADDR_W-1:0] lat_addr;
    logic [1:0]        region_sel;
    logic              erase_go;
    logic              prog_go;
    logic              pb_load;
    logic              pb_wr;
    logic              tmr_zero;
    logic              locked;
    logic [CW-1:0]     row_cnt;
    logic [7:0]        rd_byte;
    logic [PB-1:0]     pb_data;

    flash_seq_fsm #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB),
        .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_KILL(T_KILL)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_masked(irq_masked),
        .wr_en(wr_en), .wr_ctrl(wr_ctrl), .addr(addr), .wdata(wdata),
        .locked(locked), .state(st), .busy(busy), .lat_addr(lat_addr),
        .region_sel(region_sel), .erase_go(erase_go), .prog_go(prog_go),
        .pb_load(pb_load), .pb_wr(pb_wr), .tmr_zero(tmr_zero),
        .seq_err(seq_err), .mask_err(mask_err), .lock_err(lock_err)
    );

    flash_page_buf #(.PAGE_LSB(PAGE_LSB)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .load(pb_load), .wr(pb_wr),
        .idx(addr[PAGE_LSB-1:0]), .wbyte(wdata), .page_data(pb_data)
    );

    flash_cell_array #(
        .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .PAGE_LSB(PAGE_LSB), .MAX_PROG(MAX_PROG)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .prog_go(prog_go),
        .tgt_addr(lat_addr), .region_sel(region_sel), .pb_data(pb_data),
        .rd_addr(addr), .rd_byte(rd_byte), .rd_row_cnt(row_cnt)
    );

    // Lock the row at its program limit and hide array data while busy.
    always_comb begin
        locked = row_cnt >= CW'(MAX_PROG);
        rdata  = busy ? 8'h00 : rd_byte;
    end
endmodule

// File: rtl/flash_seq_chk.sv
// Checker for the sequencer's timing and flag rules. It is attached to
// the top with bind and only observes signals.
module flash_seq_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_masked,
    input logic                      wr_en,
    input logic                      wr_ctrl,
    input logic [7:0]                wdata,
    input logic [7:0]                rdata,
    input logic                      busy,
    input logic                      seq_err,
    input logic                      mask_err,
    input logic                      lock_err,
    input flash_seq_pkg::seq_state_e st,
    input logic                      erase_go,
    input logic                      prog_go,
    input logic                      tmr_zero
);
    import flash_seq_pkg::*;

    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_err, mask_err, lock_err}));

    a_r5_hv_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_ctrl && wdata[2] && irq_masked));

    a_r5_mask_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> !busy);

    a_r6_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rdata == 8'h00);

    a_r6_release_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st) == ST_DISCH && $past(tmr_zero)));

    a_r7_erase_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> ($past(st) == ST_E_HV && $past(tmr_zero)));

    a_r4_prog_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> ($past(st) == ST_P_HV && $past(tmr_zero)));

    a_r10_lock_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> st == ST_IDLE);
endmodule

bind flash_seq_ctrl flash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_masked(irq_masked), .wr_en(wr_en),
    .wr_ctrl(wr_ctrl), .wdata(wdata), .rdata(rdata), .busy(busy),
    .seq_err(seq_err), .mask_err(mask_err), .lock_err(lock_err),
    .st(st), .erase_go(erase_go), .prog_go(prog_go), .tmr_zero(tmr_zero)
);

// File: tb/flash_seq_ctrl_tb.sv
// Bench with a behavioural array model (byte array and row counters).
// Stimulus is driven on falling edges, and outputs are sampled 1 time
// unit after a falling edge.
module flash_seq_ctrl_tb;
    localparam int AW = 11;
    localparam int TE = 20;
    localparam int TP = 12;
    localparam int TK = 6;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_masked = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_ctrl = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          busy, seq_err, mask_err, lock_err;

    always #4 clk = ~clk;

    flash_seq_ctrl #(.ADDR_W(AW), .T_ERASE(TE), .T_PROG(TP), .T_KILL(TK)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_masked(irq_masked), .wr_en(wr_en),
        .wr_ctrl(wr_ctrl), .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy(busy), .seq_err(seq_err), .mask_err(mask_err), .lock_err(lock_err)
    );

    int         nvec = 0;
    int         nfail = 0;
    bit         done = 1'b0;
    logic [7:0] mdl [NB];
    int         mcnt [NB/64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle write, then check the three flags in the cycle after it.
    task automatic wr(input logic c, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [2:0] exp_flags, input string tag);
        wr_en = 1'b1; wr_ctrl = c; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk({tag, " flags"}, {29'd0, seq_err, mask_err, lock_err}, {29'd0, exp_flags});
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        addr = a;
        #1 chk(tag, rdata, mdl[a]);
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < NB; i++) rd(AW'(i), tag);
    endtask

    task automatic do_erase(input logic [1:0] sel, input logic [AW-1:0] a, input string tag);
        int lsb;
        lsb = (sel == 2'b00) ? AW : (sel == 2'b01) ? AW - 1 : (sel == 2'b10) ? 9 : 6;
        wr(1'b1, '0, {3'b000, sel, 3'b010}, 3'b000, tag);
        wr(1'b0, a, 8'h5A, 3'b000, tag);
        wr(1'b1, '0, {3'b000, sel, 3'b110}, 3'b000, tag);
        chk("R6 busy after hv set", busy, 1);
        addr = a;
        #1 chk("R6 read zero while busy", rdata, 0);
        idle(TE);
        wr(1'b1, '0, 8'h04, 3'b000, tag);
        wr(1'b1, '0, 8'h00, 3'b000, tag);
        for (int i = 0; i < NB; i++) if (((i ^ int'(a)) >> lsb) == 0) mdl[i] = 8'h00;
        for (int r = 0; r < NB/64; r++) if ((((r * 64) ^ int'(a)) >> lsb) == 0) mcnt[r] = 0;
        idle(TK);
        #1 chk("R6 busy through discharge", busy, 1);
        idle(1);
        #1 chk("R6 busy released", busy, 0);
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                           input bit extra, input string tag);
        wr(1'b1, '0, 8'h01, 3'b000, tag);
        if (extra) begin
            rd(AW'(12), "R8 read between steps");
            wr(1'b1, '0, 8'h01, 3'b000, "R8 repeated command");
        end
        for (int k = 0; k < n; k++) wr(1'b0, a + AW'(k), d ^ 8'(k * 17), 3'b000, tag);
        if (extra) rd(AW'(500), "R8 read between steps");
        wr(1'b1, '0, 8'h05, 3'b000, tag);
        idle(TP);
        wr(1'b1, '0, 8'h04, 3'b000, tag);
        wr(1'b1, '0, 8'h00, 3'b000, tag);
        for (int k = 0; k < n; k++) mdl[int'(a) + k] = mdl[int'(a) + k] | (d ^ 8'(k * 17));
        mcnt[int'(a) / 64]++;
        idle(TK + 1);
    endtask

    task automatic seed(input logic [7:0] d);
        do_prog(11'h000, d, 2, 1'b0, "R4 seed");
        do_prog(11'h048, d, 3, 1'b0, "R4 seed");
        do_prog(11'h1F0, d, 1, 1'b0, "R4 seed");
        do_prog(11'h230, d, 2, 1'b0, "R4 seed");
        do_prog(11'h408, d, 8, 1'b0, "R4 seed");
        do_prog(11'h7F8, d, 1, 1'b0, "R4 seed");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
        for (int r = 0; r < NB/64; r++) mcnt[r] = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        #1 chk("R1 reset flags", {busy, seq_err, mask_err, lock_err}, 0);
        sweep("R1 erased after reset");

        // R4: single-byte program, then OR of disjoint bits, with R8 filler.
        do_prog(11'h040, 8'h0F, 1, 1'b1, "R4 first");
        rd(11'h040, "R4 byte programmed");
        do_prog(11'h040, 8'hF0, 1, 1'b0, "R4 second");
        rd(11'h040, "R4 bits ORed");
        rd(11'h041, "R4 neighbour untouched");

        // R3: each select value.
        seed(8'h81);
        sweep("R4 seeded");
        do_erase(2'b11, 11'h04A, "R2 row erase");
        sweep("R3 single row");
        do_erase(2'b10, 11'h1C3, "R2 group erase");
        sweep("R3 eight rows");
        seed(8'h24);
        do_erase(2'b01, 11'h5A1, "R2 half erase");
        sweep("R3 half array");

        // R7: early clear aborts the erase.
        wr(1'b1, '0, 8'h02, 3'b000, "R7 arm");
        wr(1'b0, 11'h000, 8'h00, 3'b000, "R7 latch");
        wr(1'b1, '0, 8'h06, 3'b000, "R7 hv");
        idle(2);
        wr(1'b1, '0, 8'h04, 3'b100, "R7 early clear");
        #1 chk("R7 discharge after abort", busy, 1);
        wr(1'b1, '0, 8'h00, 3'b000, "R7 write during discharge");
        idle(TK);
        #1 chk("R7 released", busy, 0);

        // R5: high voltage without the interrupt mask.
        irq_masked = 1'b0;
        wr(1'b1, '0, 8'h01, 3'b000, "R5 arm");
        wr(1'b0, 11'h010, 8'hFF, 3'b000, "R5 latch");
        wr(1'b1, '0, 8'h05, 3'b010, "R5 mask error");
        #1 chk("R5 no busy", busy, 0);
        irq_masked = 1'b1;
        wr(1'b0, 11'h010, 8'hFF, 3'b100, "R9 array write when idle");
        rd(11'h010, "R5 array unchanged");

        // R9: wrong command and stray page.
        wr(1'b1, '0, 8'h02, 3'b000, "R9 arm");
        wr(1'b1, '0, 8'h01, 3'b100, "R9 wrong command");
        wr(1'b0, 11'h300, 8'h11, 3'b100, "R9 dropped sequence");
        wr(1'b1, '0, 8'h01, 3'b000, "R9 prog arm");
        wr(1'b0, 11'h200, 8'h0F, 3'b000, "R9 page pick");
        wr(1'b0, 11'h210, 8'hF0, 3'b100, "R9 other page");
        wr(1'b1, '0, 8'h05, 3'b000, "R9 hv");
        idle(TP);
        wr(1'b1, '0, 8'h04, 3'b000, "R9 clear");
        wr(1'b1, '0, 8'h00, 3'b000, "R9 off");
        mdl[11'h200] = mdl[11'h200] | 8'h0F;
        mcnt[11'h200 / 64]++;
        idle(TK + 1);
        sweep("R7 R9 array state");

        // R3 full array, then R10 lock.
        do_erase(2'b00, 11'h3FF, "R2 full erase");
        sweep("R3 full array");
        for (int k = 0; k < 8; k++)
            do_prog(AW'(256 + 8 * k), 8'(1 << k), 1, 1'b0, "R10 fill");
        wr(1'b1, '0, 8'h01, 3'b000, "R10 arm");
        wr(1'b0, 11'h108, 8'hFF, 3'b001, "R10 lock");
        wr(1'b0, 11'h108, 8'hFF, 3'b100, "R10 back to idle");
        rd(11'h108, "R10 array unchanged");
        do_erase(2'b11, 11'h13C, "R10 erase row");
        do_prog(11'h108, 8'h3C, 1, 1'b0, "R10 unlocked");
        rd(11'h108, "R10 program after erase");
        sweep("R10 final");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule